// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block is the command front end of a four-bank synchronous DRAM with a 32-bit word. On each rising clock edge it samples the chip-select, the three command strobes, the clock enable, the two bank-select bits and the eleven address bits. From these it decodes one command. It keeps, for every bank, whether that bank is open and which row is open in it. It also applies precharge rules: closing one bank, closing all banks, or closing a bank automatically when a burst ends. The memory array and the data path sit behind it and take its decoded strobe, target bank and address.

The clock enable gates the internal clock. When the enable is sampled low, the following edge is dead: commands are ignored and a running burst is frozen. If the enable drops while no burst is running, the block enters power-down and stays there until the enable is sampled high again. Bursts have a fixed length, set by a parameter. A read or write that arrives during a burst without auto-precharge cuts that burst short and starts a new one.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset every bank is closed, and cmdValid, cmdError, burstActive, powerDown and suspended are all low. cmdCode reads 3'b111.
- R2: A command is decoded when csN is low on a valid edge, from {rasN,casN,weN}: 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode set. Codes 111 and 110 produce no strobe. An accepted command drives cmdValid high for one cycle after its edge, with cmdCode equal to the code and cmdBank equal to ba. When cmdValid is low, cmdCode reads 111.
- R3: An accepted activate opens bank number ba, where the value of ba is the bank index. The 11-bit addr is stored as that bank's row, visible in bankRowFlat[11*ba +: 11]. cmdAddr carries the row, and bankActive[ba] rises one cycle after the edge.
- R4: A read or write to an open bank is accepted. cmdAddr carries addr[7:0] zero-extended to 11 bits, cmdAutoPre equals addr[10], and burstActive is high for BURST_LEN cycles.
- R5: A precharge with addr[10] low closes only bank ba. With addr[10] high it closes all banks. The change shows one cycle after the edge.
- R6: A read or write with addr[10] high closes its bank at the BURST_LEN-th valid edge after the command edge. Without auto-precharge the bank stays open.
- R7: cmdError pulses for one cycle, with no strobe and no change of state, in three cases: a read or write to a closed bank, an activate to an open bank, or a read or write issued while an auto-precharge burst is still running.
- R8: With csN high, the command inputs are ignored, but a running burst still counts down and its auto-precharge still takes place.
- R9: cke sampled low at an edge makes the next edge invalid. On an invalid edge, commands are ignored and the burst count holds. suspended is high after an edge where cke was low and a burst remains.
- R10: cke sampled low at an edge that leaves no burst running raises powerDown from the next cycle. powerDown stays high, and the bank state stays frozen, until an edge samples cke high. That edge clears powerDown and is itself still invalid.
- R11: A precharge that closes the bank waiting for auto-precharge cancels the pending close, so a row reopened in that bank during the burst stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable for the following edge |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Command bit 2 |
| casN | input | 1 | Command bit 1 |
| weN | input | 1 | Command bit 0 |
| ba | input | 2 | Bank select |
| addr | input | 11 | Row, column and precharge-mode address |
| cmdValid | output | 1 | One-cycle strobe for an accepted command |
| cmdCode | output | 3 | Accepted command code, 111 when idle |
| cmdBank | output | 2 | Target bank of the accepted command |
| cmdAddr | output | 11 | Row, or zero-extended column, of the accepted command |
| cmdAutoPre | output | 1 | Accepted read or write requests auto-precharge |
| cmdError | output | 1 | One-cycle flag for a rejected command |
| bankActive | output | 4 | Open flag per bank |
| bankRowFlat | output | 44 | Open row per bank, 11 bits each, bank 0 lowest |
| burstActive | output | 1 | A burst is running |
| powerDown | output | 1 | Device is in power-down |
| suspended | output | 1 | Clock suspended in the middle of a burst |

## Verification
A wrong bank flag shows up at bankActive one cycle after the edge that set it. It also shows up on the next access to that bank, which produces a strobe where an error was due, or the reverse. An off-by-one in the burst counter moves the auto-precharge close by one cycle, so the bench samples bankActive on every cycle around the last beat. A mistake in the clock-enable gate shows as a command accepted on a dead edge, or as a close that comes too early while the clock is suspended. The bench sweeps every command code, with the chip selected and with it deselected, over all four banks.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int ROW_W     = 11;
  localparam int COL_W     = 8;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_RSV = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef struct packed {
    logic              open;
    logic              close;
    logic              closeAll;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic              apClose;
    logic [BANK_W-1:0] apBank;
  } bankStrb_t;

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    ba,
  input  logic [ROW_W-1:0]     addr,
  input  logic [NUM_BANKS-1:0] bankActive,
  output bankStrb_t            strb,
  output logic                 cmdValid,
  output logic [2:0]           cmdCode,
  output logic [BANK_W-1:0]    cmdBank,
  output logic [ROW_W-1:0]     cmdAddr,
  output logic                 cmdAutoPre,
  output logic                 cmdError,
  output logic                 burstActive,
  output logic                 powerDown,
  output logic                 suspended
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic              ckeQ;
  logic [CNT_W-1:0]  beatCnt, beatCntNext;
  logic              apPending, apPendingNext;
  logic [BANK_W-1:0] apBank;
  cmd_e              code;
  logic              edgeValid, selCmd, tgtActive;
  logic              isAct, isRw, isPre, isRef, isMrs;
  logic              actOk, actErr, rwOk, rwErr, lastBeat, accepted;

  assign code      = cmd_e'({rasN, casN, weN});
  assign edgeValid = ckeQ;
  assign selCmd    = edgeValid && !csN;
  assign tgtActive = bankActive[ba];

  assign isAct = selCmd && (code == CMD_ACT);
  assign isRw  = selCmd && ((code == CMD_RD) || (code == CMD_WR));
  assign isPre = selCmd && (code == CMD_PRE);
  assign isRef = selCmd && (code == CMD_REF);
  assign isMrs = selCmd && (code == CMD_MRS);

  assign actErr   = isAct && tgtActive;
  assign actOk    = isAct && !tgtActive;
  assign rwErr    = isRw && (!tgtActive || apPending);
  assign rwOk     = isRw && !rwErr;
  assign accepted = actOk || rwOk || isPre || isRef || isMrs;
  assign lastBeat = edgeValid && (beatCnt == CNT_W'(1));

  always_comb begin
    beatCntNext = beatCnt;
    if (rwOk) beatCntNext = CNT_W'(BURST_LEN);
    else if (edgeValid && beatCnt != '0) beatCntNext = beatCnt - CNT_W'(1);
  end

  always_comb begin
    apPendingNext = apPending;
    if (rwOk) apPendingNext = addr[AP_BIT];
    else begin
      if (lastBeat) apPendingNext = 1'b0;
      if (isPre && (addr[AP_BIT] || ba == apBank)) apPendingNext = 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.open     = actOk;
    strb.close    = isPre;
    strb.closeAll = isPre && addr[AP_BIT];
    strb.bank     = ba;
    strb.row      = addr;
    strb.apClose  = lastBeat && apPending;
    strb.apBank   = apBank;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckeQ      <= 1'b1;
      beatCnt   <= '0;
      apPending <= 1'b0;
      apBank    <= '0;
      powerDown <= 1'b0;
      suspended <= 1'b0;
    end else begin
      ckeQ      <= cke;
      beatCnt   <= beatCntNext;
      apPending <= apPendingNext;
      if (rwOk) apBank <= ba;
      powerDown <= !cke && (beatCntNext == '0);
      suspended <= !cke && (beatCntNext != '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid   <= 1'b0;
      cmdCode    <= CMD_NOP;
      cmdBank    <= '0;
      cmdAddr    <= '0;
      cmdAutoPre <= 1'b0;
      cmdError   <= 1'b0;
    end else begin
      cmdValid   <= accepted;
      cmdCode    <= accepted ? code : CMD_NOP;
      cmdBank    <= accepted ? ba : '0;
      cmdError   <= actErr || rwErr;
      cmdAutoPre <= rwOk && addr[AP_BIT];
      if (rwOk)          cmdAddr <= {{(ROW_W-COL_W){1'b0}}, addr[COL_W-1:0]};
      else if (accepted) cmdAddr <= addr;
      else               cmdAddr <= '0;
    end
  end

  assign burstActive = (beatCnt != '0);

  assert_err_no_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> !cmdValid);
  assert_dead_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ckeQ |=> (!cmdValid && !cmdError));
  assert_pd_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> !burstActive);
  assert_pd_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> $stable(bankActive));

endmodule

// File: rtl/sdram_trk_banks.sv
module sdram_trk_banks
  import sdram_trk_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStrb_t                  strb,
  output logic [NUM_BANKS-1:0]       bankActive,
  output logic [NUM_BANKS*ROW_W-1:0] bankRowFlat
);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hitOpen, hitClose;
    assign hitOpen  = strb.open && (strb.bank == BANK_W'(i));
    assign hitClose = (strb.close && (strb.closeAll || strb.bank == BANK_W'(i)))
                   || (strb.apClose && strb.apBank == BANK_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankActive[i]                 <= 1'b0;
        bankRowFlat[i*ROW_W +: ROW_W] <= '0;
      end else if (hitOpen) begin
        bankActive[i]                 <= 1'b1;
        bankRowFlat[i*ROW_W +: ROW_W] <= strb.row;
      end else if (hitClose) begin
        bankActive[i]                 <= 1'b0;
      end
    end
  end

  assert_open_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.open |=> bankActive[$past(strb.bank)]);
  assert_close_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.close && strb.closeAll) |=> (bankActive == '0));
  assert_auto_close_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.apClose |=> !bankActive[$past(strb.apBank)]);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cke,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [BANK_W-1:0]          ba,
  input  logic [ROW_W-1:0]           addr,
  output logic                       cmdValid,
  output logic [2:0]                 cmdCode,
  output logic [BANK_W-1:0]          cmdBank,
  output logic [ROW_W-1:0]           cmdAddr,
  output logic                       cmdAutoPre,
  output logic                       cmdError,
  output logic [NUM_BANKS-1:0]       bankActive,
  output logic [NUM_BANKS*ROW_W-1:0] bankRowFlat,
  output logic                       burstActive,
  output logic                       powerDown,
  output logic                       suspended
);

  bankStrb_t strb;

  sdram_trk_ctrl #(.BURST_LEN(BURST_LEN), .AP_BIT(AP_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .bankActive(bankActive), .strb(strb),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .cmdAutoPre(cmdAutoPre), .cmdError(cmdError),
    .burstActive(burstActive), .powerDown(powerDown), .suspended(suspended)
  );

  sdram_trk_banks u_banks (
    .clk(clk), .rstN(rstN), .strb(strb),
    .bankActive(bankActive), .bankRowFlat(bankRowFlat)
  );

endmodule

// File: tb/tb_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module tb_sdram_cmd_tracker;

  logic clk = 1'b0;
  logic rstN, cke, csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [10:0] addr;
  logic cmdValid, cmdAutoPre, cmdError, burstActive, powerDown, suspended;
  logic [2:0]  cmdCode;
  logic [1:0]  cmdBank;
  logic [10:0] cmdAddr;
  logic [3:0]  bankActive;
  logic [43:0] bankRowFlat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdAddr(cmdAddr), .cmdAutoPre(cmdAutoPre),
    .cmdError(cmdError), .bankActive(bankActive), .bankRowFlat(bankRowFlat),
    .burstActive(burstActive), .powerDown(powerDown), .suspended(suspended)
  );

  task automatic drive(input logic cs, input logic [2:0] c, input logic [1:0] b,
                       input logic [10:0] a, input logic k);
    csN = cs; {rasN, casN, weN} = c; ba = b; addr = a; cke = k;
  endtask

  task automatic nop();
    drive(1'b1, 3'b111, 2'd0, 11'd0, 1'b1);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [43:0] act, input logic [43:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] rowOf(input int b);
    return 11'((b * 397 + 5) & 2047);
  endfunction

  initial begin
    logic [3:0] expAct;
    logic open0;
    rstN = 1'b0;
    nop();
    repeat (3) step();
    rstN = 1'b1;
    step();
    chk("R1", "bankActive", 44'(bankActive), 0);
    chk("R1", "cmdValid", 44'(cmdValid), 0);
    chk("R1", "cmdError", 44'(cmdError), 0);
    chk("R1", "burstActive", 44'(burstActive), 0);
    chk("R1", "powerDown", 44'(powerDown), 0);
    chk("R1", "suspended", 44'(suspended), 0);
    chk("R1", "cmdCode", 44'(cmdCode), 44'h7);

    // R3: open every bank with its own row
    expAct = 4'b0000;
    for (int b = 0; b < 4; b++) begin
      drive(1'b0, 3'b011, 2'(b), rowOf(b), 1'b1);
      step();
      expAct[b] = 1'b1;
      chk("R3", "cmdValid", 44'(cmdValid), 1);
      chk("R3", "cmdCode", 44'(cmdCode), 44'h3);
      chk("R3", "cmdBank", 44'(cmdBank), 44'(b));
      chk("R3", "cmdAddr", 44'(cmdAddr), 44'(rowOf(b)));
      chk("R3", "bankActive", 44'(bankActive), 44'(expAct));
      chk("R3", "row", 44'(bankRowFlat[b*11 +: 11]), 44'(rowOf(b)));
    end

    // R7: activate an open bank
    drive(1'b0, 3'b011, 2'd2, 11'h7FF, 1'b1);
    step();
    chk("R7", "cmdError act", 44'(cmdError), 1);
    chk("R7", "cmdValid act", 44'(cmdValid), 0);
    chk("R7", "row kept", 44'(bankRowFlat[22 +: 11]), 44'(rowOf(2)));

    // R5: single-bank then all-bank precharge
    drive(1'b0, 3'b010, 2'd1, 11'h3FF, 1'b1);
    step();
    chk("R5", "single close", 44'(bankActive), 44'hD);
    chk("R2", "pre code", 44'(cmdCode), 44'h2);
    drive(1'b0, 3'b010, 2'd1, 11'h400, 1'b1);
    step();
    chk("R5", "all close", 44'(bankActive), 0);

    // R7: read a closed bank
    drive(1'b0, 3'b101, 2'd0, 11'h000, 1'b1);
    step();
    chk("R7", "cmdError rd", 44'(cmdError), 1);
    chk("R7", "cmdValid rd", 44'(cmdValid), 0);
    chk("R7", "no burst", 44'(burstActive), 0);

    // R4/R6: auto-precharge read on bank 3
    drive(1'b0, 3'b011, 2'd3, 11'h2AB, 1'b1);
    step();
    drive(1'b0, 3'b101, 2'd3, 11'h7A5, 1'b1);
    step();
    chk("R4", "rd code", 44'(cmdCode), 44'h5);
    chk("R4", "col addr", 44'(cmdAddr), 44'h0A5);
    chk("R4", "autoPre", 44'(cmdAutoPre), 1);
    chk("R4", "burst on", 44'(burstActive), 1);
    drive(1'b0, 3'b101, 2'd3, 11'h001, 1'b1);
    step();
    chk("R7", "rd during ap", 44'(cmdError), 1);
    chk("R6", "open beat1", 44'(bankActive[3]), 1);
    nop();
    step();
    chk("R6", "open beat2", 44'(bankActive[3]), 1);
    step();
    chk("R6", "open beat3", 44'(bankActive[3]), 1);
    chk("R4", "burst beat3", 44'(burstActive), 1);
    step();
    chk("R6", "closed beat4", 44'(bankActive[3]), 0);
    chk("R4", "burst done", 44'(burstActive), 0);

    // R4/R6: write without auto-precharge keeps bank open
    drive(1'b0, 3'b011, 2'd0, 11'h005, 1'b1);
    step();
    drive(1'b0, 3'b100, 2'd0, 11'h33C, 1'b1);
    step();
    chk("R4", "wr code", 44'(cmdCode), 44'h4);
    chk("R4", "wr col", 44'(cmdAddr), 44'h03C);
    chk("R4", "wr noAp", 44'(cmdAutoPre), 0);
    nop();
    repeat (4) step();
    chk("R6", "no ap open", 44'(bankActive[0]), 1);
    chk("R4", "wr burst done", 44'(burstActive), 0);

    // R8: deselected inputs ignored, auto-precharge still happens
    drive(1'b0, 3'b101, 2'd0, 11'h400, 1'b1);
    step();
    drive(1'b1, 3'b010, 2'd0, 11'h400, 1'b1);
    repeat (3) step();
    chk("R8", "no strobe", 44'(cmdValid), 0);
    chk("R8", "still open", 44'(bankActive[0]), 1);
    step();
    chk("R8", "ap closed", 44'(bankActive[0]), 0);
    chk("R8", "no strobe end", 44'(cmdValid), 0);

    // R9: clock suspension stretches the burst by two edges
    drive(1'b0, 3'b011, 2'd1, 11'h111, 1'b1);
    step();
    drive(1'b0, 3'b101, 2'd1, 11'h401, 1'b1);
    step();
    drive(1'b1, 3'b111, 2'd0, 11'h000, 1'b0);
    step();
    chk("R9", "suspended", 44'(suspended), 1);
    drive(1'b0, 3'b011, 2'd2, 11'h222, 1'b0);
    step();
    chk("R9", "dead edge cmd", 44'(cmdValid), 0);
    chk("R9", "dead edge bank", 44'(bankActive[2]), 0);
    chk("R9", "still suspended", 44'(suspended), 1);
    chk("R9", "burst held", 44'(burstActive), 1);
    drive(1'b0, 3'b011, 2'd2, 11'h222, 1'b1);
    step();
    chk("R9", "wake edge cmd", 44'(cmdValid), 0);
    chk("R9", "wake edge bank", 44'(bankActive[2]), 0);
    chk("R9", "resume", 44'(suspended), 0);
    chk("R10", "no pd in burst", 44'(powerDown), 0);
    nop();
    step();
    step();
    chk("R9", "open late", 44'(bankActive[1]), 1);
    step();
    chk("R9", "closed late", 44'(bankActive[1]), 0);

    // R10: power-down entry, frozen state, exit
    drive(1'b0, 3'b011, 2'd0, 11'h0AA, 1'b1);
    step();
    drive(1'b1, 3'b111, 2'd0, 11'h000, 1'b0);
    step();
    chk("R10", "pd entry", 44'(powerDown), 1);
    chk("R10", "pd no burst", 44'(burstActive), 0);
    drive(1'b0, 3'b010, 2'd0, 11'h400, 1'b0);
    step();
    chk("R10", "pd held", 44'(powerDown), 1);
    chk("R10", "pd frozen", 44'(bankActive), 44'h1);
    chk("R10", "pd no strobe", 44'(cmdValid), 0);
    step();
    chk("R10", "pd frozen2", 44'(bankActive), 44'h1);
    drive(1'b0, 3'b010, 2'd0, 11'h400, 1'b1);
    step();
    chk("R10", "pd exit", 44'(powerDown), 0);
    chk("R10", "exit edge dead", 44'(cmdValid), 0);
    chk("R10", "exit frozen", 44'(bankActive), 44'h1);
    step();
    chk("R10", "after exit", 44'(cmdValid), 1);
    chk("R10", "after exit bank", 44'(bankActive), 0);

    // R11: manual precharge cancels pending auto-precharge
    drive(1'b0, 3'b011, 2'd1, 11'h155, 1'b1);
    step();
    drive(1'b0, 3'b101, 2'd1, 11'h400, 1'b1);
    step();
    drive(1'b0, 3'b010, 2'd1, 11'h000, 1'b1);
    step();
    chk("R11", "manual close", 44'(bankActive), 0);
    drive(1'b0, 3'b011, 2'd1, 11'h0F0, 1'b1);
    step();
    nop();
    repeat (4) step();
    chk("R11", "reopen kept", 44'(bankActive[1]), 1);
    chk("R11", "reopen row", 44'(bankRowFlat[11 +: 11]), 44'h0F0);

    // R2: sweep all codes, selected and deselected
    drive(1'b0, 3'b010, 2'd0, 11'h400, 1'b1);
    step();
    open0 = 1'b0;
    for (int cs = 0; cs < 2; cs++) begin
      for (int c = 7; c >= 0; c--) begin
        logic expV, expE;
        expV = 1'b0; expE = 1'b0;
        if (cs == 0) begin
          case (c)
            5, 4: begin expE = !open0; expV = open0; end
            3: begin expE = open0; expV = !open0; if (!open0) open0 = 1'b1; end
            2: begin expV = 1'b1; open0 = 1'b0; end
            1, 0: expV = 1'b1;
            default: ;
          endcase
        end
        drive(1'(cs), 3'(c), 2'd0, 11'h000, 1'b1);
        step();
        chk("R2", "sweep valid", 44'(cmdValid), 44'(expV));
        chk("R2", "sweep error", 44'(cmdError), 44'(expE));
        chk("R2", "sweep code", 44'(cmdCode), expV ? 44'(c) : 44'h7);
        chk("R2", "sweep bank0", 44'(bankActive[0]), 44'(open0));
        if (expV || expE) begin
          nop();
          repeat (5) step();
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #250000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule